// File: doc/BRIEF.md
# SD Command Path Engine

This block sends a single SD command on the command line and, when asked to, collects the card's response. Software loads a 32-bit argument and then a command word. The top bit of the command word is a start flag. When the engine takes the command it builds a 48-bit frame: a start bit, a transmission bit, the index, the argument, a CRC7 and an end bit. It shifts the frame out most significant bit first, one bit per card-clock tick.

If the command word asks for a response, the engine releases the line and waits for the card's first low bit. It then receives either a 48-bit or a 136-bit response. It checks the framing and, when enabled, the CRC. It stores the payload in four response words and signals completion on single-cycle event outputs. Two other features are available. A command can be held back until the data lines stop signalling busy. A command can be a clock-only update, which pulses a strobe and sends nothing on the line.

Top module: `sd_cmd_engine`

## Requirements
- R1: A taken command appears on `cmd_out` with `cmd_oe` high for exactly 48 bits, MSB first: 0, 1, index (command word bits 5:0), argument, CRC7 (x^7+x^3+1, zero seed, over the first 40 bits), 1. The start flag (command word bit 31) reads 0 once the command is taken.
- R2: With bit 6 (response expected) clear, the engine pulses `ev_done` after the last frame bit. It raises no other event and leaves `cmd_oe` low.
- R3: With bit 6 set and bit 7 clear, a 48-bit response starting at the first low bit on `cmd_in` stores its bits 39:8 in response word 0 (`resp_words[31:0]`). Words 1 to 3 are left unchanged. Bits 45:40 become the last response index in `status[16:11]`, and `ev_done` pulses.
- R4: With bits 6 and 7 set, a 136-bit response stores its last 128 bits in `resp_words`, least significant word in bits 31:0.
- R5: With bit 8 set, a CRC7 mismatch pulses `ev_crc_err` together with `ev_done`. The CRC covers bits 0..39 of a short response and bits 8..127 of a long one, counted from the first bit received. With bit 8 clear, no CRC error is reported.
- R6: A response whose end bit is 0 or whose transmission bit (second bit) is 1 pulses `ev_resp_err` with `ev_done`.
- R7: If `cmd_in` stays high for T sampled ticks after the frame, `ev_timeout` and `ev_done` pulse and nothing is stored. T is the timeout register value, reset value 64, and 0 means 256. A response that starts on tick T or earlier is accepted.
- R8: With bit 13 set, the engine does not start while `data_busy` is high: `cmd_oe` stays low and the start flag stays 1. It starts after `data_busy` falls.
- R9: With bit 21 set, the engine pulses `clk_update` once, clears the start flag, sends nothing on the line and raises no event.
- R10: `status[7:4]` gives the engine state: 0 idle, 1 waiting for data busy, 2 sending, 3 waiting for a response, 4 receiving. All other status bits except 16:11 read 0.
- R11: A write to the command word while the start flag is set or the engine is not idle is ignored.
- R12: The frame, the response sampling and the timeout advance only on cycles where `bit_tick` is high, so each frame bit lasts one tick period.
- R13: After reset `cmd_out` is 1, `cmd_oe` is 0, and the command word, status and response words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Card clock strobe, one bit per high cycle |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word write data |
| tmo_wr | input | 1 | Response timeout register write strobe |
| tmo_wdata | input | TMO_W | Response timeout in ticks |
| data_busy | input | 1 | Data lines signalling busy |
| cmd_in | input | 1 | Command line input from the card |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| clk_update | output | 1 | Clock-only update strobe |
| cmd_word | output | 32 | Command word read-back |
| status | output | 32 | Engine state and last response index |
| resp_words | output | 128 | Four response words, word 0 lowest |
| ev_done | output | 1 | Command finished pulse |
| ev_resp_err | output | 1 | Bad response framing pulse |
| ev_crc_err | output | 1 | Response CRC mismatch pulse |
| ev_timeout | output | 1 | Response timeout pulse |

## Verification
The bench builds the engine with its default 8-bit timeout register. A reset value of 64 and a programmed value of 5 bring the exact timeout boundary within reach: a response starting on tick 5 is accepted and one starting on tick 6 is not. Programming 0 exercises the 256-tick meaning in a few hundred cycles. Most scenarios run the tick strobe every cycle. One runs it every third cycle to show that the frame stretches evenly.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam int ARG_W         = 32;
    localparam int IDX_W         = 6;
    localparam int CRC_W         = 7;
    localparam int CMD_FRAME_W   = 2 + IDX_W + ARG_W + CRC_W + 1;
    localparam int CRC_SPAN      = 2 + IDX_W + ARG_W;
    localparam int SHORT_RESP_W  = 48;
    localparam int LONG_RESP_W   = 136;
    localparam int LONG_CRC_SKIP = 8;
    localparam int RESP_STORE_W  = 128;

    // command word bit positions
    localparam int CW_START   = 31;
    localparam int CW_CLKONLY = 21;
    localparam int CW_WAITDAT = 13;
    localparam int CW_CRCCHK  = 8;
    localparam int CW_LONG    = 7;
    localparam int CW_RESP    = 6;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_BUSYWAIT = 4'd1,
        ST_SEND     = 4'd2,
        ST_RESPWAIT = 4'd3,
        ST_RECV     = 4'd4
    } eng_state_e;

    typedef struct packed {
        logic             start;
        logic             clk_only;
        logic             wait_dat;
        logic             crc_chk;
        logic             long_rsp;
        logic             rsp_exp;
        logic [IDX_W-1:0] idx;
    } cmd_flags_t;

    function automatic cmd_flags_t decode_cmd(input logic [31:0] w);
        cmd_flags_t f;
        f.start    = w[CW_START];
        f.clk_only = w[CW_CLKONLY];
        f.wait_dat = w[CW_WAITDAT];
        f.crc_chk  = w[CW_CRCCHK];
        f.long_rsp = w[CW_LONG];
        f.rsp_exp  = w[CW_RESP];
        f.idx      = w[IDX_W-1:0];
        return f;
    endfunction

    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [CRC_W-1:0] crc7_block(input logic [CRC_SPAN-1:0] d);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = CRC_SPAN - 1; i >= 0; i--) begin
            c = crc7_step(c, d[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7
    import sd_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc7_step(crc, din);
        end
    end
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
    import sd_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic             line,
    output logic             active,
    output logic             last
);
    localparam int CNT_W = $clog2(CMD_FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CMD_FRAME_W - 1);

    logic [CMD_FRAME_W-1:0] sh;
    logic [CNT_W-1:0]       cnt;
    logic [CRC_SPAN-1:0]    head;

    assign head = {2'b01, idx, arg};
    assign last = active && (cnt == LAST_BIT);
    assign line = active ? sh[CMD_FRAME_W-1] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            sh     <= {head, crc7_block(head), 1'b1};
            cnt    <= '0;
            active <= 1'b1;
        end else if (active && tick) begin
            if (cnt == LAST_BIT) begin
                active <= 1'b0;
            end else begin
                sh  <= {sh[CMD_FRAME_W-2:0], 1'b0};
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_TX_OPENS_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> !line) else $error("frame did not open with a low bit"); // R1
    AST_TX_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(tick)) |-> $stable(line)) else $error("line moved without tick"); // R12
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
    import sd_cmd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   en,
    input  logic                   tick,
    input  logic                   long_mode,
    input  logic                   din,
    output logic                   done_q,
    output logic [LONG_RESP_W-1:0] sh,
    output logic                   crc_ok,
    output logic                   frame_ok,
    output logic [IDX_W-1:0]       idx
);
    localparam int CNT_W = $clog2(LONG_RESP_W);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_RESP_W - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_RESP_W - 1);
    localparam logic [CNT_W-1:0] SHORT_HI   = CNT_W'(CRC_SPAN - 1);
    localparam logic [CNT_W-1:0] LONG_LO    = CNT_W'(LONG_CRC_SKIP);
    localparam logic [CNT_W-1:0] LONG_HI    = CNT_W'(RESP_STORE_W - 1);

    logic             started, finished, accept, crc_en;
    logic [CNT_W-1:0] cnt, ix, last_ix, lo, hi;
    logic [CRC_W-1:0] crc;

    assign ix      = started ? cnt : '0;
    assign last_ix = long_mode ? LONG_LAST : SHORT_LAST;
    assign lo      = long_mode ? LONG_LO : '0;
    assign hi      = long_mode ? LONG_HI : SHORT_HI;
    assign accept  = en && tick && !finished && (started || !din);
    assign crc_en  = accept && (ix >= lo) && (ix <= hi);

    sd_cmd_crc7 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .en  (crc_en),
        .din (din),
        .crc (crc)
    );

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst || clr) begin
            sh       <= '0;
            cnt      <= '0;
            started  <= 1'b0;
            finished <= 1'b0;
            done_q   <= 1'b0;
        end else if (accept) begin
            sh <= {sh[LONG_RESP_W-2:0], din};
            if (ix == last_ix) begin
                started  <= 1'b0;
                finished <= 1'b1;
                done_q   <= 1'b1;
            end else begin
                started <= 1'b1;
                cnt     <= ix + 1'b1;
            end
        end
    end

    assign crc_ok   = (crc == sh[CRC_W:1]);
    assign frame_ok = sh[0] && !(long_mode ? sh[LONG_RESP_W-2] : sh[SHORT_RESP_W-2]);
    assign idx      = long_mode ? sh[LONG_RESP_W-3 -: IDX_W] : sh[SHORT_RESP_W-3 -: IDX_W];

    AST_RX_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        started |-> (cnt <= last_ix)) else $error("receive count past frame length"); // R4
    AST_RX_DONE_FINISHED: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (finished && !started)) else $error("done without finished frame"); // R3
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int TMO_W = 8,
    parameter logic [TMO_W-1:0] TMO_RESET = TMO_W'(64)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_tick,
    input  logic                    arg_wr,
    input  logic [ARG_W-1:0]        arg_wdata,
    input  logic                    cmd_wr,
    input  logic [31:0]             cmd_wdata,
    input  logic                    tmo_wr,
    input  logic [TMO_W-1:0]        tmo_wdata,
    input  logic                    data_busy,
    input  logic                    cmd_in,
    output logic                    cmd_out,
    output logic                    cmd_oe,
    output logic                    clk_update,
    output logic [31:0]             cmd_word,
    output logic [31:0]             status,
    output logic [RESP_STORE_W-1:0] resp_words,
    output logic                    ev_done,
    output logic                    ev_resp_err,
    output logic                    ev_crc_err,
    output logic                    ev_timeout
);
    eng_state_e             state;
    logic [ARG_W-1:0]       arg_q;
    logic [31:0]            cmd_q;
    logic [TMO_W-1:0]       tmo_q, tmo_cnt;
    logic [IDX_W-1:0]       last_idx;
    cmd_flags_t             fl;
    logic                   go, tx_load, tx_active, tx_last, tx_line;
    logic                   rx_done, rx_crc_ok, rx_frame_ok, rx_en;
    logic [LONG_RESP_W-1:0] rx_sh;
    logic [IDX_W-1:0]       rx_idx;

    assign fl = decode_cmd(cmd_q);
    assign go = bit_tick && fl.start &&
                (((state == ST_IDLE) && !(fl.wait_dat && data_busy)) ||
                 ((state == ST_BUSYWAIT) && !data_busy));
    assign tx_load = go && !fl.clk_only;
    assign rx_en   = (state == ST_RESPWAIT) || (state == ST_RECV);

    sd_cmd_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .tick   (bit_tick),
        .load   (tx_load),
        .idx    (fl.idx),
        .arg    (arg_q),
        .line   (tx_line),
        .active (tx_active),
        .last   (tx_last)
    );

    sd_cmd_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr       (tx_load),
        .en        (rx_en),
        .tick      (bit_tick),
        .long_mode (fl.long_rsp),
        .din       (cmd_in),
        .done_q    (rx_done),
        .sh        (rx_sh),
        .crc_ok    (rx_crc_ok),
        .frame_ok  (rx_frame_ok),
        .idx       (rx_idx)
    );

    always_ff @(posedge clk) begin
        ev_done     <= 1'b0;
        ev_resp_err <= 1'b0;
        ev_crc_err  <= 1'b0;
        ev_timeout  <= 1'b0;
        clk_update  <= 1'b0;
        if (rst) begin
            state      <= ST_IDLE;
            arg_q      <= '0;
            cmd_q      <= '0;
            tmo_q      <= TMO_RESET;
            tmo_cnt    <= '0;
            last_idx   <= '0;
            resp_words <= '0;
        end else begin
            if (arg_wr) arg_q <= arg_wdata;
            if (tmo_wr) tmo_q <= tmo_wdata;
            if (cmd_wr && (state == ST_IDLE) && !cmd_q[CW_START]) cmd_q <= cmd_wdata;

            if (go) begin
                cmd_q[CW_START] <= 1'b0;
                if (fl.clk_only) begin
                    clk_update <= 1'b1;
                    state      <= ST_IDLE;
                end else begin
                    state <= ST_SEND;
                end
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (bit_tick && fl.start && fl.wait_dat && data_busy) state <= ST_BUSYWAIT;
                    end
                    ST_BUSYWAIT: ;
                    ST_SEND: begin
                        if (bit_tick && tx_last) begin
                            tmo_cnt <= '0;
                            if (fl.rsp_exp) begin
                                state <= ST_RESPWAIT;
                            end else begin
                                ev_done <= 1'b1;
                                state   <= ST_IDLE;
                            end
                        end
                    end
                    ST_RESPWAIT: begin
                        if (bit_tick) begin
                            if (!cmd_in) begin
                                state <= ST_RECV;
                            end else if (tmo_cnt == tmo_q - TMO_W'(1)) begin
                                ev_timeout <= 1'b1;
                                ev_done    <= 1'b1;
                                state      <= ST_IDLE;
                            end else begin
                                tmo_cnt <= tmo_cnt + TMO_W'(1);
                            end
                        end
                    end
                    ST_RECV: begin
                        if (rx_done) begin
                            if (fl.long_rsp) resp_words <= rx_sh[RESP_STORE_W-1:0];
                            else resp_words[ARG_W-1:0] <= rx_sh[CRC_SPAN-1:CRC_W+1];
                            last_idx    <= rx_idx;
                            ev_done     <= 1'b1;
                            ev_crc_err  <= fl.crc_chk && !rx_crc_ok;
                            ev_resp_err <= !rx_frame_ok;
                            state       <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign cmd_out  = tx_line;
    assign cmd_oe   = tx_active;
    assign cmd_word = cmd_q;
    assign status   = {15'b0, last_idx, 3'b0, state, 4'b0};

    AST_CRC_ERR_ENDS_CMD: assert property (@(posedge clk) disable iff (rst)
        ev_crc_err |-> ev_done) else $error("crc error without done"); // R5
    AST_TIMEOUT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        ev_timeout |-> (ev_done && !ev_crc_err && !ev_resp_err)) else $error("timeout mixed with response events"); // R7
    AST_BUSY_HOLDS_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSYWAIT) |-> (cmd_q[CW_START] && !cmd_oe)) else $error("busy wait lost start or drove line"); // R8
    AST_CLKUPD_QUIET: assert property (@(posedge clk) disable iff (rst)
        clk_update |-> (!cmd_oe && !cmd_q[CW_START] && !ev_done)) else $error("clock update touched line"); // R9
    AST_OE_ONLY_SENDING: assert property (@(posedge clk) disable iff (rst)
        cmd_oe |-> (state == ST_SEND)) else $error("line driven outside send"); // R10
    AST_WORD_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        ((state != ST_IDLE) && ($past(state) != ST_IDLE)) |-> $stable(cmd_q[30:0])) else $error("command word changed mid command"); // R11
endmodule

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bit_tick = 1'b1;
    logic         arg_wr = 1'b0, cmd_wr = 1'b0, tmo_wr = 1'b0;
    logic [31:0]  arg_wdata = '0, cmd_wdata = '0;
    logic [7:0]   tmo_wdata = '0;
    logic         data_busy = 1'b0, cmd_in = 1'b1;
    logic         cmd_out, cmd_oe, clk_update;
    logic [31:0]  cmd_word, status;
    logic [127:0] resp_words;
    logic         ev_done, ev_resp_err, ev_crc_err, ev_timeout;

    int n_checks = 0, n_fail = 0;
    int tick_div = 1, ph = 0;
    int n_done = 0, n_rerr = 0, n_cerr = 0, n_tmo = 0, n_clk = 0, n_oe = 0, n_tx = 0;
    logic [47:0] txbuf = '0;
    bit finished = 0;

    sd_cmd_engine u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick),
        .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata),
        .data_busy(data_busy), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .clk_update(clk_update),
        .cmd_word(cmd_word), .status(status), .resp_words(resp_words),
        .ev_done(ev_done), .ev_resp_err(ev_resp_err),
        .ev_crc_err(ev_crc_err), .ev_timeout(ev_timeout)
    );

    always #4 clk = ~clk;

    // tick strobe, updated at the falling edge
    initial forever begin
        @(negedge clk);
        ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
        bit_tick = (ph == 0);
    end

    // monitor, just before each rising edge
    initial forever begin
        @(negedge clk);
        #3;
        if (!rst) begin
            if (ev_done) n_done++;
            if (ev_resp_err) n_rerr++;
            if (ev_crc_err) n_cerr++;
            if (ev_timeout) n_tmo++;
            if (clk_update) n_clk++;
            if (cmd_oe) n_oe++;
            if (cmd_oe && bit_tick) begin
                txbuf = {txbuf[46:0], cmd_out};
                n_tx++;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
        summary();
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] bcrc(input logic [127:0] d, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic top = c[6] ^ d[i];
            c = {c[5:0], 1'b0};
            if (top) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    function automatic logic [47:0] mk_cmd(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h = {2'b01, idx, arg};
        return {h, bcrc({88'b0, h}, 40), 1'b1};
    endfunction

    function automatic logic [47:0] mk_short(input logic [5:0] idx, input logic [31:0] pl,
                                             input bit flip, input bit endb, input bit trans);
        logic [39:0] h = {1'b0, trans, idx, pl};
        return {h, bcrc({88'b0, h}, 40) ^ {6'b0, flip}, endb};
    endfunction

    function automatic logic [135:0] mk_long(input logic [119:0] body);
        return {2'b00, 6'h3F, body, bcrc({8'b0, body}, 120), 1'b1};
    endfunction

    task automatic clr_mon();
        n_done = 0; n_rerr = 0; n_cerr = 0; n_tmo = 0; n_clk = 0; n_oe = 0; n_tx = 0;
    endtask

    task automatic wr_arg(input logic [31:0] v);
        @(negedge clk); #1; arg_wr = 1; arg_wdata = v;
        @(negedge clk); #1; arg_wr = 0;
    endtask

    task automatic wr_cmd(input logic [31:0] v);
        @(negedge clk); #1; cmd_wr = 1; cmd_wdata = v;
        @(negedge clk); #1; cmd_wr = 0;
    endtask

    task automatic wr_tmo(input logic [7:0] v);
        @(negedge clk); #1; tmo_wr = 1; tmo_wdata = v;
        @(negedge clk); #1; tmo_wr = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && n_done == 0; i++) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // after the frame ends, hold high for dly ticks, then shift out len bits MSB first
    task automatic drive_resp(input logic [135:0] bits, input int len, input int dly);
        do begin @(negedge clk); #1; end while (!cmd_oe);
        do begin @(negedge clk); #1; end while (cmd_oe);
        for (int i = 0; i < dly + len; i++) begin
            while (!bit_tick) begin @(negedge clk); #1; end
            cmd_in = (i < dly) ? 1'b1 : bits[len - 1 - (i - dly)];
            @(negedge clk); #1;
        end
        while (!bit_tick) begin @(negedge clk); #1; end
        cmd_in = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk); #3;
        chk(cmd_out === 1'b1 && cmd_oe === 1'b0, "R13 line idle", {cmd_out, cmd_oe}, 2'b10);
        chk(cmd_word === 32'h0 && status === 32'h0, "R13 regs zero", {cmd_word, status}, 0);
        chk(resp_words === 128'h0, "R13 resp zero", resp_words, 0);
    endtask

    task automatic t_noresp();
        clr_mon();
        wr_arg(32'h0);
        wr_cmd(32'h8000_0000);
        wait_done();
        chk(txbuf === 48'h4000_0000_0095, "R1 go-idle frame", txbuf, 48'h4000_0000_0095);
        chk(n_tx == 48 && n_oe == 48, "R1 frame length", n_oe, 48);
        chk(cmd_word[31] === 1'b0, "R1 start cleared", cmd_word, 0);
        chk(n_done == 1 && n_rerr == 0 && n_cerr == 0 && n_tmo == 0, "R2 only done", {n_done, n_rerr, n_cerr, n_tmo}, 1);
        chk(cmd_oe === 1'b0 && cmd_out === 1'b1, "R2 line released", cmd_oe, 0);
    endtask

    task automatic t_frame_arg();
        clr_mon();
        wr_arg(32'h1234_ABCD);
        wr_cmd(32'h8000_0011);
        wait_done();
        chk(txbuf === mk_cmd(6'h11, 32'h1234_ABCD), "R1 frame with argument", txbuf, mk_cmd(6'h11, 32'h1234_ABCD));
    endtask

    task automatic t_short();
        logic [47:0] r = mk_short(6'd13, 32'hDEAD_BEEF, 0, 1, 0);
        clr_mon();
        wr_arg(32'h0001_0000);
        wr_cmd(32'h8000_014D);
        drive_resp({88'b0, r}, 48, 2);
        wait_done();
        chk(resp_words[31:0] === 32'hDEAD_BEEF, "R3 short payload", resp_words[31:0], 32'hDEAD_BEEF);
        chk(resp_words[127:32] === 96'h0, "R3 upper words kept", resp_words[127:32], 0);
        chk(status[16:11] === 6'd13, "R3 last index", status[16:11], 13);
        chk(n_done == 1 && n_cerr == 0 && n_rerr == 0, "R5 clean crc", {n_done, n_cerr, n_rerr}, 1);
    endtask

    task automatic t_long();
        logic [119:0] body = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
        logic [135:0] r = mk_long(body);
        clr_mon();
        wr_cmd(32'h8000_01C2);
        drive_resp(r, 136, 1);
        wait_done();
        chk(resp_words === r[127:0], "R4 long response words", resp_words, r[127:0]);
        chk(n_done == 1 && n_cerr == 0 && n_rerr == 0, "R5 long crc skips head", {n_cerr, n_rerr}, 0);
        chk(status[16:11] === 6'h3F, "R3 long index field", status[16:11], 6'h3F);
    endtask

    task automatic t_crc();
        logic [47:0] r = mk_short(6'd7, 32'h5555_AAAA, 1, 1, 0);
        clr_mon();
        wr_cmd(32'h8000_0147);
        drive_resp({88'b0, r}, 48, 0);
        wait_done();
        chk(n_cerr == 1 && n_done == 1 && n_rerr == 0, "R5 crc mismatch flagged", n_cerr, 1);
        clr_mon();
        wr_cmd(32'h8000_0047);
        drive_resp({88'b0, r}, 48, 0);
        wait_done();
        chk(n_cerr == 0 && n_done == 1, "R5 crc check off", n_cerr, 0);
    endtask

    task automatic t_resp_err();
        logic [47:0] r = mk_short(6'd8, 32'h0, 0, 0, 0);
        clr_mon();
        wr_cmd(32'h8000_0148);
        drive_resp({88'b0, r}, 48, 0);
        wait_done();
        chk(n_rerr == 1 && n_done == 1, "R6 end bit low", n_rerr, 1);
        r = mk_short(6'd8, 32'h0, 0, 1, 1);
        clr_mon();
        wr_cmd(32'h8000_0148);
        drive_resp({88'b0, r}, 48, 0);
        wait_done();
        chk(n_rerr == 1 && n_cerr == 0, "R6 transmission bit high", n_rerr, 1);
    endtask

    task automatic t_timeout();
        logic [47:0] r = mk_short(6'd9, 32'hCAFE_0009, 0, 1, 0);
        wr_tmo(8'd5);
        clr_mon();
        wr_cmd(32'h8000_0149);
        drive_resp({88'b0, r}, 48, 4);
        wait_done();
        chk(n_tmo == 0 && resp_words[31:0] === 32'hCAFE_0009, "R7 start on last allowed tick", resp_words[31:0], 32'hCAFE_0009);
        r = mk_short(6'd10, 32'hBAD0_0010, 0, 1, 0);
        clr_mon();
        wr_cmd(32'h8000_014A);
        drive_resp({88'b0, r}, 48, 5);
        repeat (20) @(posedge clk);
        chk(n_tmo == 1 && n_done == 1, "R7 timeout raised", {n_tmo, n_done}, 2'b11);
        chk(resp_words[31:0] === 32'hCAFE_0009, "R7 nothing stored", resp_words[31:0], 32'hCAFE_0009);
        wr_tmo(8'd0);
        r = mk_short(6'd11, 32'h0000_0256, 0, 1, 0);
        clr_mon();
        wr_cmd(32'h8000_014B);
        drive_resp({88'b0, r}, 48, 200);
        wait_done();
        chk(n_tmo == 0 && resp_words[31:0] === 32'h0000_0256, "R7 zero means 256", n_tmo, 0);
        wr_tmo(8'd64);
    endtask

    task automatic t_busy();
        clr_mon();
        data_busy = 1'b1;
        wr_cmd(32'h8000_2005);
        repeat (20) @(posedge clk);
        @(negedge clk); #3;
        chk(n_oe == 0 && cmd_word[31] === 1'b1, "R8 held while busy", {n_oe, cmd_word[31]}, 1);
        chk(status[7:4] === 4'd1, "R10 busy-wait state", status[7:4], 1);
        data_busy = 1'b0;
        wait_done();
        chk(n_tx == 48 && n_done == 1, "R8 sends after busy drops", n_tx, 48);
        clr_mon();
        data_busy = 1'b1;
        wr_cmd(32'h8000_0005);
        wait_done();
        data_busy = 1'b0;
        chk(n_tx == 48, "R8 busy ignored without wait flag", n_tx, 48);
    endtask

    task automatic t_status_send();
        clr_mon();
        wr_cmd(32'h8000_0003);
        do begin @(negedge clk); #3; end while (!cmd_oe);
        chk(status[7:4] === 4'd2 && status[31:17] === 0 && status[10:8] === 0 && status[3:0] === 0,
            "R10 sending state", status, 32'h20);
        wr_cmd(32'h8000_003F);
        wait_done();
        chk(cmd_word === 32'h0000_0003, "R11 write ignored mid command", cmd_word, 32'h3);
        repeat (60) @(posedge clk);
        chk(n_tx == 48, "R11 no second frame", n_tx, 48);
        @(negedge clk); #3;
        chk(status[7:4] === 4'd0, "R10 idle state", status[7:4], 0);
    endtask

    task automatic t_clkonly();
        clr_mon();
        wr_cmd(32'h8020_0000);
        repeat (10) @(posedge clk);
        chk(n_clk == 1 && n_oe == 0 && n_done == 0, "R9 strobe only", {n_clk, n_oe, n_done}, 1);
        chk(cmd_word[31] === 1'b0, "R9 start cleared", cmd_word[31], 0);
    endtask

    task automatic t_slow_tick();
        tick_div = 3;
        clr_mon();
        wr_arg(32'h0F0F_F0F0);
        wr_cmd(32'h8000_0021);
        wait_done();
        chk(n_oe == 144, "R12 bit lasts one tick period", n_oe, 144);
        chk(txbuf === mk_cmd(6'h21, 32'h0F0F_F0F0), "R12 frame at slow tick", txbuf, mk_cmd(6'h21, 32'h0F0F_F0F0));
        tick_div = 1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); #1; rst = 1'b0;
        t_reset();
        t_noresp();
        t_frame_arg();
        t_short();
        t_long();
        t_crc();
        t_resp_err();
        t_timeout();
        t_busy();
        t_status_send();
        t_clkonly();
        t_slow_tick();
        summary();
    end
endmodule